// File: doc/BRIEF.md
# Delayed-Load Register Scoreboard

This block is the issue-side hazard check of a load/store pipeline in which load data arrives some cycles after the load issues. It keeps one lock bit per architectural register. An accepted load sets the lock of its destination. The lock clears when that load's data arrives. Each cycle the block looks at the instruction offered for issue. If it reads or writes a register whose lock is still set, issue is held with `stall`. Otherwise the instruction is taken with `accept`. Instructions that do not depend on a pending load therefore keep flowing. The pipeline does not stop for a fixed time after every load.

Completion can come from two sources, chosen by the `EXT_DONE` parameter. With `EXT_DONE = 0`, the default, the block keeps a countdown per register. It raises the completion itself `LAT` cycles after the load issues; `LAT` defaults to 2. With `EXT_DONE = 1`, the memory side reports each arriving load on `done_vld`/`done_reg`. The release always takes effect in the same cycle it occurs. A dependent instruction offered in that cycle therefore issues without losing a cycle.

Register 0 is a constant register and never holds a lock. An instruction with fewer operands names register 0 in its unused source or destination fields.

Top module: `ld_lock_board`

## Requirements
- R1: After reset every lock is clear: `stall` is 0, and the first valid instruction is accepted whatever registers it names.
- R2: An accepted load (`iss_load` = 1) whose destination is not register 0 locks that destination from the next cycle on.
- R3: A valid instruction that names no locked register is accepted in the same cycle, with `stall` low.
- R4: A valid instruction whose source `iss_rs1` or `iss_rs2` is locked raises `stall` and is not accepted.
- R5: A valid instruction whose destination `iss_rd` is locked (write after write) raises `stall` and is not accepted.
- R6: Register 0 is never locked: a load targeting it locks nothing, and naming it never stalls.
- R7: With `EXT_DONE` = 0, a load issued in cycle t releases its register in cycle t+`LAT`. A dependent instruction stalls in cycles t+1 to t+`LAT`-1 and is accepted in cycle t+`LAT`.
- R8: With `EXT_DONE` = 1, `done_vld` with register number `done_reg` releases that register in the same cycle. A dependent instruction offered in that cycle is accepted.
- R9: When a load to register r is accepted in the same cycle as the completion for r, register r is locked afterwards.
- R10: `stall` and `accept` are never high together, and neither is high when `iss_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_vld | input | 1 | An instruction is offered for issue |
| iss_load | input | 1 | The offered instruction is a load |
| iss_rs1 | input | RW | First source register (0 when unused) |
| iss_rs2 | input | RW | Second source register (0 when unused) |
| iss_rd | input | RW | Destination register (0 when none) |
| done_vld | input | 1 | Load completion strobe (used when EXT_DONE = 1) |
| done_reg | input | RW | Register whose load completes |
| stall | output | 1 | Offered instruction must wait |
| accept | output | 1 | Offered instruction issues this cycle |

## Verification
The bound checker checks the following on every cycle:
- `stall` and `accept` are never high together, and neither is high without `iss_vld` (R10).
- A valid instruction that is not stalled is accepted (R3).
- Register 0 never holds a lock (R6).
- Every accepted load leaves its destination locked, including when a completion for the same register arrives in that cycle (R2, R9).
- Reset empties the lock set (R1).

Which instruction must stall depends on the history of loads and completions. Only the bench shows this. It runs a reference model of both completion modes and compares it with directed sequences and seeded random traffic. These cover:
- the `LAT`-cycle release timing (R7);
- a release arriving together with a dependent instruction (R8);
- write-after-write holds (R5).

// File: rtl/ld_lock_board.sv
module ld_lock_board #(
  parameter int NREG = 32,
  parameter int LAT = 2,
  parameter bit EXT_DONE = 1'b0,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_vld,
  input  logic          iss_load,
  input  logic [RW-1:0] iss_rs1,
  input  logic [RW-1:0] iss_rs2,
  input  logic [RW-1:0] iss_rd,
  input  logic          done_vld,
  input  logic [RW-1:0] done_reg,
  output logic          stall,
  output logic          accept
);

  logic [NREG-1:0] lock_q;
  logic [NREG-1:0] clr;
  logic [NREG-1:0] set_v;
  logic [NREG-1:0] eff;
  logic            hazard;

  generate
    if (EXT_DONE) begin : g_ext
      assign clr = done_vld ? (NREG'(1) << done_reg) : '0;
    end else begin : g_int
      localparam int CW = $clog2(LAT + 1);
      logic unused_done;
      assign unused_done = ^{done_vld, done_reg};
      for (genvar r = 0; r < NREG; r++) begin : g_cnt
        logic [CW-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)          cnt <= '0;
          else if (set_v[r])   cnt <= CW'(LAT);
          else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
        assign clr[r] = (cnt == CW'(1));
      end
    end
  endgenerate

  assign eff    = lock_q & ~clr;
  assign hazard = eff[iss_rs1] | eff[iss_rs2] | eff[iss_rd];
  assign stall  = iss_vld & hazard;
  assign accept = iss_vld & ~hazard;

  assign set_v = (accept && iss_load && iss_rd != '0) ? (NREG'(1) << iss_rd) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= ((lock_q & ~clr) | set_v) & ~NREG'(1);
  end

endmodule

// File: rtl/ld_lock_board_chk.sv
module ld_lock_board_chk #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_vld,
  input logic            iss_load,
  input logic [RW-1:0]   iss_rd,
  input logic            stall,
  input logic            accept,
  input logic [NREG-1:0] lock_q
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && accept));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || accept) |-> iss_vld);

  p_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !stall) |-> accept);

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[0] == 1'b0);

  // R2 and R9: a completion in the same cycle must not cancel the new lock
  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && iss_load && iss_rd != '0) |=> lock_q[$past(iss_rd)]);

  always @(negedge clk) begin
    if (!rst_n) p_rst_r1: assert (lock_q == '0);
  end

endmodule

bind ld_lock_board ld_lock_board_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_load(iss_load),
  .iss_rd(iss_rd), .stall(stall), .accept(accept), .lock_q(lock_q)
);

// File: tb/tb_ld_lock_board.sv
module tb_ld_lock_board;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       vld, ld, dvld;
  logic [4:0] rs1, rs2, rd, dreg;
  logic       st_i, ac_i, st_x, ac_x;

  ld_lock_board dut (
    .clk(clk), .rst_n(rst_n), .iss_vld(vld), .iss_load(ld),
    .iss_rs1(rs1), .iss_rs2(rs2), .iss_rd(rd),
    .done_vld(dvld), .done_reg(dreg), .stall(st_i), .accept(ac_i));

  ld_lock_board #(.EXT_DONE(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .iss_vld(vld), .iss_load(ld),
    .iss_rs1(rs1), .iss_rs2(rs2), .iss_rd(rd),
    .done_vld(dvld), .done_reg(dreg), .stall(st_x), .accept(ac_x));

  int total = 0;
  int bad = 0;
  logic [31:0] lk_i, lk_x;
  int cnt [32];

  task automatic chk(string tg, string nm, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tg, nm, act, exp);
    end
  endtask

  function automatic logic hz(logic [31:0] e);
    return vld & (e[rs1] | e[rs2] | e[rd]);
  endfunction

  task automatic drive(logic v, logic l, logic [4:0] a, logic [4:0] b,
                       logic [4:0] d, logic dv, logic [4:0] dr);
    vld = v; ld = l; rs1 = a; rs2 = b; rd = d; dvld = dv; dreg = dr;
  endtask

  task automatic step(string tg);
    logic [31:0] ci, cx, ei, ex;
    logic hi, hx;
    for (int r = 0; r < 32; r++) ci[r] = (cnt[r] == 1);
    cx = dvld ? (32'd1 << dreg) : 32'd0;
    ei = lk_i & ~ci;
    ex = lk_x & ~cx;
    hi = hz(ei);
    hx = hz(ex);
    #2;
    chk(tg, "stall_int", st_i, hi);
    chk(tg, "accept_int", ac_i, vld & ~hi);
    chk(tg, "stall_ext", st_x, hx);
    chk(tg, "accept_ext", ac_x, vld & ~hx);
    @(posedge clk);
    for (int r = 0; r < 32; r++) if (cnt[r] != 0) cnt[r]--;
    lk_i = lk_i & ~ci;
    lk_x = lk_x & ~cx;
    if (rst_n && vld && ld && !hi && rd != 0) begin lk_i[rd] = 1'b1; cnt[rd] = 2; end
    if (rst_n && vld && ld && !hx && rd != 0) lk_x[rd] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(4321));
    lk_i = '0; lk_x = '0;
    for (int r = 0; r < 32; r++) cnt[r] = 0;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    step("R1");
    rst_n = 1'b1;
    @(negedge clk);

    drive(1, 0, 1, 31, 17, 0, 0);   step("R1");
    drive(1, 1, 2, 3, 0, 0, 0);     step("R6");
    drive(1, 0, 0, 0, 0, 0, 0);     step("R6");
    drive(1, 1, 1, 2, 7, 0, 0);     step("R2");
    drive(1, 0, 7, 0, 4, 0, 0);     step("R4");
    drive(1, 0, 7, 0, 4, 0, 0);     step("R7");
    drive(1, 0, 1, 2, 7, 0, 0);     step("R5");
    drive(1, 0, 0, 7, 4, 1, 7);     step("R8");
    drive(1, 1, 1, 2, 9, 0, 0);     step("R2");
    drive(1, 0, 4, 6, 5, 0, 0);     step("R3");
    drive(1, 1, 1, 2, 9, 1, 9);     step("R9");
    drive(1, 0, 9, 0, 0, 0, 0);     step("R9");
    drive(0, 0, 9, 9, 9, 0, 0);     step("R10");
    drive(1, 0, 0, 0, 0, 1, 9);     step("R3");

    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 4) != 0, ($urandom % 3) == 0,
            5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
            ($urandom % 3) == 0, 5'($urandom % 8));
      step("R3 R4 R5 R7 R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule